// File: doc/BRIEF.md
# Retriggerable Watchdog with Locked Mode Register

This block is a one-shot watchdog for a small processor core. After power-on it stays idle until software issues its first refresh. From then on it counts steps of a chosen time base, and each later refresh sends the count back to zero. If the count reaches the programmed terminal value, the block drives a reset pulse of fixed length. It then clears its count and goes idle again.

A five-bit mode register sets the following:
- the timeout length, chosen from four taps;
- whether counting continues while the core is halted;
- whether counting continues while the core is stopped;
- which step source drives the counter: the free-running RC enable or the external crystal enable.

Software may write the register only during a short window. The window opens after power-on, after the start of each watchdog reset pulse, and after each stop-mode wake. A board strap selects a permanent mode. In that mode the watchdog runs from reset and needs no refresh to start. It re-arms itself after every pulse and disregards the halt and stop enable bits.

Top module: `wdog_ctl`

## Requirements
- R1: While `por_i` is high and after it falls, `wd_rst_o` is low and the mode register holds 5'b00101. With `perm_i` low, no pulse occurs until the first refresh, however many steps arrive.
- R2: A refresh (`kick_i` high at a clock edge) enables the watchdog and sets the count to zero. A step at that same edge is discarded. Each later refresh restarts the count. `wd_rst_o` rises at the edge of the L-th step after the last refresh.
- R3: Mode bits 1:0 select L, the number of steps, as (BASE_TICKS << s) >> SCALE_SHR, where s is 0, 1, 2 or 4 for the codes 00, 01, 10 and 11.
- R4: Mode bit 4 chooses the step source. With 0, only `rc_tick_i` advances the count. With 1, only `ext_tick_i` advances it. The unselected enable has no effect.
- R5: While `halt_i` is high, the count advances only if mode bit 2 is 1. Otherwise the count is frozen, and it resumes from the held value when the halt ends.
- R6: While `stop_i` is high, the count advances only if mode bit 4 is 0 and mode bit 3 is 1. With bit 4 set to 1, the count never advances in stop.
- R7: `wd_rst_o` stays high for exactly PULSE_LEN cycles. After the pulse the watchdog is idle with a zero count. A refresh made during the pulse is ignored.
- R8: A write (`wr_en_i` high, `wr_data_i` bits laid out as in R3 to R6) is accepted only at one of the first WIN_CYCLES clock edges after one of these events: `por_i` falls, a reset pulse starts, or `wake_i` is sampled high. Writes at any other edge leave the register unchanged.
- R9: With `perm_i` high, the watchdog counts from reset without a refresh and re-arms after every pulse. It counts in halt whatever bit 2 holds. In stop it counts exactly when bit 4 is 0, whatever bit 3 holds. The tap and the source still come from the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| rc_tick_i | input | 1 | One-cycle step enable from the RC oscillator domain |
| ext_tick_i | input | 1 | One-cycle step enable from the external clock |
| kick_i | input | 1 | Refresh strobe |
| halt_i | input | 1 | Core is in halt mode |
| stop_i | input | 1 | Core is in stop mode |
| wake_i | input | 1 | Stop-mode wake event; reopens the write window |
| perm_i | input | 1 | Permanent-mode strap |
| wr_en_i | input | 1 | Mode register write strobe |
| wr_data_i | input | 5 | Mode register write data |
| wd_rst_o | output | 1 | Watchdog reset pulse |

## Verification
The hardest state to reach is the edge of the write window. A write must land exactly on the last edge that is still open, or on the first edge after it closes. Its effect can be seen only later, through the length of the timeout. The bench releases power-on reset on a falling edge and counts rising edges from there, so that the write falls on edge WIN_CYCLES or WIN_CYCLES+1. It then measures the next timeout to learn which tap is in force. A frozen-then-resumed count during halt is reached the same way: the bench lets a known number of steps through, holds halt, and then measures only the remaining steps.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   localparam int MODE_W = 5;

   // Field order matters: software writes these positions.
   typedef struct packed {
      logic       src_ext;   // 4: 1 = external step source
      logic       stop_run;  // 3: count while stopped (RC source only)
      logic       halt_run;  // 2: count while halted
      logic [1:0] tap;       // 1:0: timeout tap
   } wdog_mode_t;

   localparam wdog_mode_t MODE_RST = '{src_ext: 1'b0, stop_run: 1'b0,
                                       halt_run: 1'b1, tap: 2'b01};

   function automatic int tap_shift(input logic [1:0] t);
      case (t)
         2'd0:    return 0;
         2'd1:    return 1;
         2'd2:    return 2;
         default: return 4;
      endcase
   endfunction

endpackage

// File: rtl/wdog_modereg.sv
module wdog_modereg
   import wdog_pkg::*;
#(
   parameter int WIN_CYCLES = 60
) (
   input  logic       clk,
   input  logic       por_i,
   input  logic       restart_i,
   input  logic       wr_en_i,
   input  wdog_mode_t wr_data_i,
   output wdog_mode_t mode_o,
   output logic       open_o
);

   localparam int WIN_W = $clog2(WIN_CYCLES + 1);

   logic [WIN_W-1:0] win_q;
   wdog_mode_t       mode_q;

   assign open_o = (win_q < WIN_W'(WIN_CYCLES));
   assign mode_o = mode_q;

   always_ff @(posedge clk or posedge por_i) begin
      if (por_i) begin
         win_q  <= '0;
         mode_q <= MODE_RST;
      end else begin
         if (wr_en_i && open_o) mode_q <= wr_data_i;
         if (restart_i)         win_q  <= '0;
         else if (open_o)       win_q  <= win_q + 1'b1;
      end
   end

endmodule

// File: rtl/wdog_gate.sv
module wdog_gate
   import wdog_pkg::*;
(
   input  wdog_mode_t mode_i,
   input  logic       perm_i,
   input  logic       halt_i,
   input  logic       stop_i,
   input  logic       rc_tick_i,
   input  logic       ext_tick_i,
   output logic       step_o
);

   logic tick;
   logic allow;

   always_comb begin
      tick = mode_i.src_ext ? ext_tick_i : rc_tick_i;
      if (stop_i)      allow = !mode_i.src_ext && (perm_i || mode_i.stop_run);
      else if (halt_i) allow = perm_i || mode_i.halt_run;
      else             allow = 1'b1;
      step_o = tick && allow;
   end

endmodule

// File: rtl/wdog_core.sv
module wdog_core
   import wdog_pkg::*;
#(
   parameter int BASE_TICKS = 128,
   parameter int SCALE_SHR  = 0,
   parameter int PULSE_LEN  = 4,
   parameter int CNT_W      = 11
) (
   input  logic       clk,
   input  logic       por_i,
   input  logic       perm_i,
   input  logic       kick_i,
   input  logic       step_i,
   input  logic [1:0] tap_i,
   output logic       fire_o,
   output logic       rst_o
);

   localparam int PW = $clog2(PULSE_LEN + 1);

   logic [CNT_W-1:0] lim_last [4];
   logic [CNT_W-1:0] cnt_q;
   logic [PW-1:0]    pls_q;
   logic             en_q;
   logic             busy;
   logic             active;

   for (genvar g = 0; g < 4; g++) begin : g_tap
      localparam int LIM = (BASE_TICKS << tap_shift(2'(g))) >> SCALE_SHR;
      assign lim_last[g] = CNT_W'(LIM - 1);
   end

   assign busy   = (pls_q != '0);
   assign active = (en_q || perm_i) && !busy;
   assign fire_o = active && step_i && !kick_i && (cnt_q >= lim_last[tap_i]);
   assign rst_o  = busy;

   always_ff @(posedge clk or posedge por_i) begin
      if (por_i) begin
         en_q  <= 1'b0;
         cnt_q <= '0;
         pls_q <= '0;
      end else begin
         if (busy) pls_q <= pls_q - 1'b1;
         if (fire_o) begin
            pls_q <= PW'(PULSE_LEN);
            cnt_q <= '0;
            en_q  <= 1'b0;
         end else if (kick_i && !busy) begin
            cnt_q <= '0;
            en_q  <= 1'b1;
         end else if (active && step_i) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/wdog_ctl.sv
module wdog_ctl
   import wdog_pkg::*;
#(
   parameter int BASE_TICKS = 128,
   parameter int SCALE_SHR  = 0,
   parameter int PULSE_LEN  = 4,
   parameter int WIN_CYCLES = 60
) (
   input  logic              clk,
   input  logic              por_i,
   input  logic              rc_tick_i,
   input  logic              ext_tick_i,
   input  logic              kick_i,
   input  logic              halt_i,
   input  logic              stop_i,
   input  logic              wake_i,
   input  logic              perm_i,
   input  logic              wr_en_i,
   input  logic [MODE_W-1:0] wr_data_i,
   output logic              wd_rst_o
);

   localparam int CNT_W = $clog2((BASE_TICKS << 4) >> SCALE_SHR);

   if (PULSE_LEN < 1) begin : g_bad_pulse
      $error("wdog_ctl: PULSE_LEN must be at least 1");
   end
   if (WIN_CYCLES < 1) begin : g_bad_win
      $error("wdog_ctl: WIN_CYCLES must be at least 1");
   end
   if ((BASE_TICKS >> SCALE_SHR) < 2) begin : g_bad_scale
      $error("wdog_ctl: shortest tap must be at least 2 steps");
   end

   wdog_mode_t        mode;
   logic [MODE_W-1:0] mode_w;
   logic              fire_w;
   logic              step_w;
   logic              win_open;

   assign mode_w = mode;

   wdog_modereg #(.WIN_CYCLES(WIN_CYCLES)) u_mode (
      .clk       (clk),
      .por_i     (por_i),
      .restart_i (wake_i || fire_w),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wdog_mode_t'(wr_data_i)),
      .mode_o    (mode),
      .open_o    (win_open)
   );

   wdog_gate u_gate (
      .mode_i     (mode),
      .perm_i     (perm_i),
      .halt_i     (halt_i),
      .stop_i     (stop_i),
      .rc_tick_i  (rc_tick_i),
      .ext_tick_i (ext_tick_i),
      .step_o     (step_w)
   );

   wdog_core #(
      .BASE_TICKS (BASE_TICKS),
      .SCALE_SHR  (SCALE_SHR),
      .PULSE_LEN  (PULSE_LEN),
      .CNT_W      (CNT_W)
   ) u_core (
      .clk    (clk),
      .por_i  (por_i),
      .perm_i (perm_i),
      .kick_i (kick_i),
      .step_i (step_w),
      .tap_i  (mode.tap),
      .fire_o (fire_w),
      .rst_o  (wd_rst_o)
   );

   logic unused_open;
   assign unused_open = win_open;

endmodule

// File: rtl/wdog_ctl_chk.sv
module wdog_ctl_chk #(
   parameter int PULSE_LEN  = 4,
   parameter int WIN_CYCLES = 60
) (
   input logic       clk,
   input logic       por_i,
   input logic       kick_i,
   input logic       wake_i,
   input logic       wr_en_i,
   input logic       stop_i,
   input logic       rc_tick_i,
   input logic       ext_tick_i,
   input logic       perm_i,
   input logic       wd_rst_o,
   input logic       fire,
   input logic [4:0] mode_q
);

   logic [15:0] hi_cnt;
   logic [15:0] win_cnt;
   logic        armed;

   always_ff @(posedge clk or posedge por_i) begin
      if (por_i) begin
         hi_cnt  <= '0;
         win_cnt <= '0;
         armed   <= 1'b0;
      end else begin
         hi_cnt <= wd_rst_o ? hi_cnt + 1'b1 : '0;
         if (wake_i || fire)                 win_cnt <= '0;
         else if (win_cnt < 16'(WIN_CYCLES)) win_cnt <= win_cnt + 1'b1;
         if (fire)                      armed <= 1'b0;
         else if (kick_i && !wd_rst_o)  armed <= 1'b1;
      end
   end

   // R1
   idle_until_kick_chk: assert property (@(posedge clk) disable iff (por_i)
      $rose(wd_rst_o) |-> ($past(armed) || perm_i));

   // R2
   kick_defers_chk: assert property (@(posedge clk) disable iff (por_i)
      (kick_i && !wd_rst_o) |=> !$rose(wd_rst_o));

   // R4
   needs_step_chk: assert property (@(posedge clk) disable iff (por_i)
      $rose(wd_rst_o) |-> $past(rc_tick_i || ext_tick_i));

   // R6
   ext_stop_frozen_chk: assert property (@(posedge clk) disable iff (por_i)
      (stop_i && mode_q[4]) |=> !$rose(wd_rst_o));

   // R7
   pulse_len_chk: assert property (@(posedge clk) disable iff (por_i)
      $fell(wd_rst_o) |-> (hi_cnt == 16'(PULSE_LEN)));

   // R8
   late_write_chk: assert property (@(posedge clk) disable iff (por_i)
      (wr_en_i && win_cnt >= 16'(WIN_CYCLES)) |=> $stable(mode_q));

endmodule

bind wdog_ctl wdog_ctl_chk #(.PULSE_LEN(PULSE_LEN), .WIN_CYCLES(WIN_CYCLES)) chk_i (
   .clk        (clk),
   .por_i      (por_i),
   .kick_i     (kick_i),
   .wake_i     (wake_i),
   .wr_en_i    (wr_en_i),
   .stop_i     (stop_i),
   .rc_tick_i  (rc_tick_i),
   .ext_tick_i (ext_tick_i),
   .perm_i     (perm_i),
   .wd_rst_o   (wd_rst_o),
   .fire       (fire_w),
   .mode_q     (mode_w)
);

// File: tb/wdog_ctl_tb_top.sv
module wdog_ctl_tb_top;

   localparam int SCALE = 4;
   localparam int PLEN  = 3;
   localparam int WIN   = 60;
   localparam int BOUND = 300;

   logic clk = 1'b0;
   logic por = 1'b1;
   logic rc = 1'b0, ext = 1'b0, kick = 1'b0, halt = 1'b0, stop = 1'b0;
   logic wake = 1'b0, perm = 1'b0, wr_en = 1'b0;
   logic [4:0] wr_data = '0;
   logic rst_o;

   int errs = 0;
   int checks = 0;
   int n;

   always #5 clk = ~clk;

   wdog_ctl #(.BASE_TICKS(128), .SCALE_SHR(SCALE), .PULSE_LEN(PLEN), .WIN_CYCLES(WIN)) dut_i (
      .clk(clk), .por_i(por), .rc_tick_i(rc), .ext_tick_i(ext), .kick_i(kick),
      .halt_i(halt), .stop_i(stop), .wake_i(wake), .perm_i(perm),
      .wr_en_i(wr_en), .wr_data_i(wr_data), .wd_rst_o(rst_o));

   typedef struct packed {
      logic [4:0] mode;
      logic       rc_on;
      logic       ext_on;
      logic [15:0] exp;   // edges from refresh to pulse, 0 = none
   } vec_t;

   localparam vec_t VEC [7] = '{
      '{mode: 5'b00100, rc_on: 1'b1, ext_on: 1'b0, exp: 16'd9},    // R3 tap 00 -> 8
      '{mode: 5'b00101, rc_on: 1'b1, ext_on: 1'b0, exp: 16'd17},   // R3 tap 01 -> 16
      '{mode: 5'b00110, rc_on: 1'b1, ext_on: 1'b0, exp: 16'd33},   // R3 tap 10 -> 32
      '{mode: 5'b00111, rc_on: 1'b1, ext_on: 1'b0, exp: 16'd129},  // R3 tap 11 -> 128
      '{mode: 5'b10101, rc_on: 1'b0, ext_on: 1'b1, exp: 16'd17},   // R4 external
      '{mode: 5'b10100, rc_on: 1'b1, ext_on: 1'b0, exp: 16'd0},    // R4 rc ignored
      '{mode: 5'b00100, rc_on: 1'b0, ext_on: 1'b1, exp: 16'd0}     // R4 ext ignored
   };

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_por(input logic strap);
      @(negedge clk);
      por = 1'b1; rc = 0; ext = 0; kick = 0; halt = 0; stop = 0; wake = 0; wr_en = 0;
      perm = strap;
      repeat (2) @(negedge clk);
      por = 1'b0;
   endtask

   task automatic write_mode(input logic [4:0] m);
      wr_en = 1'b1; wr_data = m;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // counts rising edges until the pulse is seen; 0 if none within BOUND
   task automatic measure(output int cnt);
      cnt = 0;
      for (int i = 1; i <= BOUND; i++) begin
         @(posedge clk);
         @(negedge clk);
         kick = 1'b0;
         if (rst_o) begin cnt = i; break; end
      end
   endtask

   task automatic kick_measure(output int cnt);
      kick = 1'b1;
      measure(cnt);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      // R1 reset state and idle without refresh
      @(negedge clk);
      check(rst_o == 1'b0, "R1 output during POR", int'(rst_o), 0);
      do_por(1'b0);
      rc = 1'b1;
      measure(n);
      check(n == 0, "R1 no pulse before refresh", n, 0);
      kick_measure(n);
      check(n == 17, "R1 default tap 01", n, 17);

      // table walk: R3 / R4
      foreach (VEC[i]) begin
         do_por(1'b0);
         write_mode(VEC[i].mode);
         rc = VEC[i].rc_on; ext = VEC[i].ext_on;
         kick_measure(n);
         check(n == int'(VEC[i].exp), $sformatf("R3/R4 vector %0d", i), n, int'(VEC[i].exp));
      end

      // R7 pulse length, idle afterwards, refresh during pulse ignored
      do_por(1'b0);
      write_mode(5'b00100);
      rc = 1'b1;
      kick_measure(n);
      n = 0;
      kick = 1'b1;
      while (rst_o && n < 20) begin n++; @(negedge clk); kick = 1'b0; end
      check(n == PLEN, "R7 pulse width", n, PLEN);
      measure(n);
      check(n == 0, "R7 idle after pulse", n, 0);

      // R2 retrigger holds off the pulse
      do_por(1'b0);
      write_mode(5'b00101);
      rc = 1'b1;
      n = 0;
      for (int k = 0; k < 8; k++) begin
         kick = 1'b1;
         @(negedge clk); kick = 1'b0;
         repeat (10) begin @(negedge clk); if (rst_o) n++; end
      end
      check(n == 0, "R2 refreshes keep pulse away", n, 0);
      kick_measure(n);
      check(n == 17, "R2 restart from zero", n, 17);

      // R5 halt freezes the count and it resumes
      do_por(1'b0);
      write_mode(5'b00000);
      rc = 1'b1;
      kick = 1'b1;
      @(negedge clk); kick = 1'b0;
      repeat (3) @(negedge clk);
      halt = 1'b1;
      n = 0;
      repeat (50) begin @(negedge clk); if (rst_o) n++; end
      check(n == 0, "R5 frozen in halt", n, 0);
      halt = 1'b0;
      measure(n);
      check(n == 5, "R5 resume from held count", n, 5);
      do_por(1'b0);
      rc = 1'b1; halt = 1'b1;
      kick_measure(n);
      check(n == 17, "R5 counts in halt when enabled", n, 17);

      // R6 stop behaviour
      do_por(1'b0);
      write_mode(5'b01100);
      rc = 1'b1; stop = 1'b1;
      kick_measure(n);
      check(n == 9, "R6 rc counts in stop", n, 9);
      do_por(1'b0);
      write_mode(5'b00100);
      rc = 1'b1; stop = 1'b1;
      kick_measure(n);
      check(n == 0, "R6 stop disabled", n, 0);
      do_por(1'b0);
      write_mode(5'b11100);
      ext = 1'b1; stop = 1'b1;
      kick_measure(n);
      check(n == 0, "R6 external source frozen in stop", n, 0);

      // R8 write window edges
      do_por(1'b0);
      repeat (WIN - 1) @(posedge clk);
      @(negedge clk);
      write_mode(5'b00100);
      rc = 1'b1;
      kick_measure(n);
      check(n == 9, "R8 last open edge accepted", n, 9);
      do_por(1'b0);
      repeat (WIN) @(posedge clk);
      @(negedge clk);
      write_mode(5'b00100);
      rc = 1'b1;
      kick_measure(n);
      check(n == 17, "R8 first closed edge ignored", n, 17);
      do_por(1'b0);
      repeat (WIN + 5) @(negedge clk);
      wake = 1'b1;
      @(negedge clk); wake = 1'b0;
      write_mode(5'b00100);
      rc = 1'b1;
      kick_measure(n);
      check(n == 9, "R8 wake reopens window", n, 9);

      // R9 permanent mode
      do_por(1'b1);
      rc = 1'b1;
      measure(n);
      check(n == 16, "R9 runs without refresh", n, 16);
      while (rst_o) @(negedge clk);
      measure(n);
      check(n == 16, "R9 rearms after pulse", n, 16);
      do_por(1'b1);
      halt = 1'b1; rc = 1'b1;
      write_mode(5'b00001);
      measure(n);
      check(n == 15, "R9 halt bit overridden", n, 15);
      do_por(1'b1);
      stop = 1'b1; rc = 1'b1;
      write_mode(5'b00001);
      measure(n);
      check(n == 15, "R9 stop with rc source", n, 15);
      do_por(1'b1);
      stop = 1'b1; ext = 1'b1;
      write_mode(5'b11001);
      measure(n);
      check(n == 0, "R9 stop with external source", n, 0);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule